// File: doc/BRIEF.md
# Multi-Converter Sync Bring-Up Sequencer

This block steps one converter device through the ordered bring-up that lets several converters sharing a clock and a sync line end up phase aligned. After a start strobe it performs a fixed series of configuration register writes over a simple request/acknowledge write port. It emits two sync pulses at the correct points. It then checks a FIFO alarm input before clearing the clock-divider sync enable. The same run is repeated for every device to be aligned.

Each register write holds its request until the acknowledge arrives. A write that is not acknowledged in time aborts the run with a timeout error. An alarm seen at the check step also stops the run in an error state, and the divider sync enable is left untouched. A completed run raises a done flag. Both the done flag and any error stay up until the next start.

Top module: `sync_bringup_seq`

## Requirements
- R1: After reset, wr_req_o, sync_o, busy_o, done_o and err_o are low and err_code_o is 0.
- R2: start_i starts a run only while the block is idle, done or in error. A start while busy_o is high is ignored, and the run continues with an unchanged write and pulse sequence.
- R3: The first write goes to address PLL_ADDR (default 0x18) with data 0x0003. Bit 0 selects dual sync source mode and bit 1 enables divider reset from sync.
- R4: After the first write, sync_o gives one pulse. Its width is the sync_len_i value captured at start, and a value of 0 gives 4 cycles. sync_o is then low for at least one cycle before the next write.
- R5: Straight after that pulse, a write to PLL_ADDR with data 0x0001 clears the divider-reset enable and keeps dual sync mode set.
- R6: A write to CLK_ADDR (default 0x00) with data 0x0001 follows, where bit 0 is the clock-divider sync enable. A second sync pulse of the same width comes after it.
- R7: alarm_i is sampled once, after the second pulse. If it is high, the run stops with err_o high and err_code_o = 1, and no further write is issued.
- R8: If alarm_i is low at the check, a final write to CLK_ADDR with data 0x0000 is issued, and done_o then rises.
- R9: A write completes in a cycle where wr_req_o and wr_ack_i are both high. Until that cycle, wr_req_o, wr_addr_o and wr_data_o hold steady.
- R10: If a write request sees no acknowledge in ACK_TIMEOUT consecutive request cycles, the request drops. The run then stops with err_o high and err_code_o = 2. An acknowledge in the last of those cycles still completes the write.
- R11: done_o and err_o are never high together. Each stays high until the next accepted start, and both are low in the cycle after it.
- R12: sync_o and wr_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one run |
| sync_len_i | input | LEN_W | Sync pulse width in cycles, 0 selects the default |
| alarm_i | input | 1 | FIFO alarm from the device |
| wr_ack_i | input | 1 | Write acknowledge from the transport |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write register address |
| wr_data_o | output | DATA_W | Write register data |
| sync_o | output | 1 | Sync pulse to the device |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run finished cleanly |
| err_o | output | 1 | Last run stopped on an error |
| err_code_o | output | 2 | 0 none, 1 alarm, 2 acknowledge timeout |

## Verification
The bench records every completed write and every sync pulse width, and compares the whole sequence with an ordering built from the requirements. A design that swapped the divider-reset clear and the clock-divider sync write, or that skipped the one-cycle gap after a pulse, fails that comparison. The acknowledge is delayed by exactly ACK_TIMEOUT-1 cycles in one run and withheld for each write in turn in others. An off-by-one timeout either aborts a legal write or lets a dead one hang, and both show up as a wrong error code or stall length. Runs with the alarm set, a zero pulse length and a start strobe in mid-run catch a design that clears divider sync after an alarm, emits zero-width pulses, or restarts while busy.

// File: rtl/sync_bringup_pkg.sv
package sync_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_DIV_ARM,
    ST_PULSE_A,
    ST_WR_DIV_DISARM,
    ST_WR_CLK_ON,
    ST_PULSE_B,
    ST_CHECK,
    ST_WR_CLK_OFF,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALARM   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_code_e;

  typedef enum logic [1:0] {
    WS_DIV_ARM,
    WS_DIV_DISARM,
    WS_CLK_ON,
    WS_CLK_OFF
  } wr_step_e;

  localparam int MODE_BIT    = 0;
  localparam int DIVRST_BIT  = 1;
  localparam int CLKSYNC_BIT = 0;

endpackage

// File: rtl/sync_bringup_wr.sv
module sync_bringup_wr
  import sync_bringup_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int ACK_TIMEOUT = 64,
  parameter logic [ADDR_W-1:0] PLL_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] CLK_ADDR = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ack_i,
  input  wr_step_e          step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              xfer_o,
  output logic              timeout_o
);

  localparam int CNT_W = $clog2(ACK_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_TIMEOUT - 1);

  logic [CNT_W-1:0] wait_q;

  assign xfer_o    = req_i && ack_i;
  assign timeout_o = req_i && !ack_i && (wait_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           wait_q <= '0;
    else if (!req_i || ack_i || timeout_o) wait_q <= '0;
    else                                   wait_q <= wait_q + 1'b1;
  end

  always_comb begin
    addr_o = PLL_ADDR;
    data_o = '0;
    unique case (step_i)
      WS_DIV_ARM: begin
        data_o[MODE_BIT]   = 1'b1;
        data_o[DIVRST_BIT] = 1'b1;
      end
      WS_DIV_DISARM: data_o[MODE_BIT] = 1'b1;
      WS_CLK_ON: begin
        addr_o              = CLK_ADDR;
        data_o[CLKSYNC_BIT] = 1'b1;
      end
      WS_CLK_OFF: addr_o = CLK_ADDR;
      default: ;
    endcase
  end

  // R10: wait counter never passes the timeout limit
  assert_wait_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q <= LAST);

  // R9: counter only runs across a held, unacknowledged request
  assert_wait_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q != '0) |-> $past(req_i) && !$past(ack_i));

endmodule

// File: rtl/sync_bringup_pulse.sv
module sync_bringup_pulse #(
  parameter int LEN_W   = 4,
  parameter int DEF_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sync_o,
  output logic             fin_o
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (len_i == '0) ? LEN_W'(DEF_LEN) : len_i;
  assign sync_o  = en_i && (cnt_q < eff_len);
  assign fin_o   = en_i && (cnt_q == eff_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || fin_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R4: pulse is high from the first enabled cycle
  assert_pulse_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> sync_o);

  // R4: a pulse ends with its low cycle, never by dropping the enable
  assert_pulse_whole_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> en_i);

endmodule

// File: rtl/sync_bringup_seq.sv
module sync_bringup_seq
  import sync_bringup_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 4,
  parameter int DEF_LEN     = 4,
  parameter int ACK_TIMEOUT = 64,
  parameter logic [ADDR_W-1:0] PLL_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] CLK_ADDR = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  sync_len_i,
  input  logic              alarm_i,
  input  logic              wr_ack_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sync_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);

  seq_state_e       state_q, state_d;
  err_code_e        code_q, code_d;
  logic [LEN_W-1:0] len_q;
  wr_step_e         step;
  logic             wr_xfer, wr_tmo, pulse_en, pulse_fin, accept;

  always_comb begin
    step = WS_DIV_ARM;
    unique case (state_q)
      ST_WR_DIV_DISARM: step = WS_DIV_DISARM;
      ST_WR_CLK_ON:     step = WS_CLK_ON;
      ST_WR_CLK_OFF:    step = WS_CLK_OFF;
      default:          step = WS_DIV_ARM;
    endcase
  end

  assign wr_req_o = (state_q == ST_WR_DIV_ARM) || (state_q == ST_WR_DIV_DISARM) ||
                    (state_q == ST_WR_CLK_ON)  || (state_q == ST_WR_CLK_OFF);
  assign pulse_en = (state_q == ST_PULSE_A) || (state_q == ST_PULSE_B);
  assign done_o   = (state_q == ST_DONE);
  assign err_o    = (state_q == ST_ERR);
  assign busy_o   = !(state_q == ST_IDLE || done_o || err_o);
  assign accept   = start_i && !busy_o;
  assign err_code_o = code_q;

  sync_bringup_wr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_TIMEOUT(ACK_TIMEOUT),
    .PLL_ADDR(PLL_ADDR), .CLK_ADDR(CLK_ADDR)
  ) u_wr (
    .clk_i, .rst_ni,
    .req_i(wr_req_o), .ack_i(wr_ack_i), .step_i(step),
    .addr_o(wr_addr_o), .data_o(wr_data_o),
    .xfer_o(wr_xfer), .timeout_o(wr_tmo)
  );

  sync_bringup_pulse #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_pulse (
    .clk_i, .rst_ni,
    .en_i(pulse_en), .len_i(len_q),
    .sync_o(sync_o), .fin_o(pulse_fin)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (accept) begin
      state_d = ST_WR_DIV_ARM;
      code_d  = ERR_NONE;
    end else if (wr_req_o && wr_tmo) begin
      state_d = ST_ERR;
      code_d  = ERR_TIMEOUT;
    end else begin
      unique case (state_q)
        ST_WR_DIV_ARM:    if (wr_xfer)   state_d = ST_PULSE_A;
        ST_PULSE_A:       if (pulse_fin) state_d = ST_WR_DIV_DISARM;
        ST_WR_DIV_DISARM: if (wr_xfer)   state_d = ST_WR_CLK_ON;
        ST_WR_CLK_ON:     if (wr_xfer)   state_d = ST_PULSE_B;
        ST_PULSE_B:       if (pulse_fin) state_d = ST_CHECK;
        ST_CHECK: begin
          if (alarm_i) begin
            state_d = ST_ERR;
            code_d  = ERR_ALARM;
          end else begin
            state_d = ST_WR_CLK_OFF;
          end
        end
        ST_WR_CLK_OFF:    if (wr_xfer)   state_d = ST_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (accept) len_q <= sync_len_i;
    end
  end

  // R9: an unacknowledged request holds address and data
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i && !wr_tmo |=>
      wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R10: timeout aborts the write into the timeout error
  assert_tmo_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tmo |=> err_o && !wr_req_o && (err_code_o == ERR_TIMEOUT));

  // R7: alarm at the check stops the run without a further write
  assert_alarm_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK) && alarm_i |=> err_o && !wr_req_o && (err_code_o == ERR_ALARM));

  // R11: status flags exclusive
  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R7: an error always carries a cause
  assert_err_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != ERR_NONE));

  // R12: pulse and write never overlap
  assert_sync_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_o && wr_req_o));

  // R2: a start while busy leaves the run in progress
  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !wr_tmo && !(state_q == ST_CHECK && alarm_i) |=> busy_o || done_o);

endmodule

// File: tb/sync_bringup_seq_test.sv
module sync_bringup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;
  localparam logic [7:0] PLL_A = 8'h18;
  localparam logic [7:0] CLK_A = 8'h00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  sync_len = '0;
  logic        alarm = 1'b0;
  logic        wr_ack = 1'b0;
  logic        wr_req, sync, busy, done, err;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  err_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int ev_k [0:15];
  int ev_a [0:15];
  int ev_d [0:15];
  int n_ev = 0;
  int wr_idx = 0;
  int wcnt = 0;
  int cur_delay = 0;
  int delay_mode = 2;
  int stall_idx = -1;
  int stall_cycles = 0;
  int run_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_bringup_seq #(.ACK_TIMEOUT(TMO), .PLL_ADDR(PLL_A), .CLK_ADDR(CLK_A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sync_len_i(sync_len),
    .alarm_i(alarm), .wr_ack_i(wr_ack), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .sync_o(sync), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(err_code)
  );

  function automatic int pick_delay(int idx);
    if (idx == stall_idx) return 100000;
    case (delay_mode)
      0:       return $urandom_range(0, TMO - 1);
      1:       return TMO - 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transport model and event monitor, all at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      wr_ack = 1'b0;
      wcnt = 0;
      run_len = 0;
    end else begin
      wr_ack = wr_req && (wcnt >= cur_delay);
      if (wr_ack) begin
        if (n_ev < 16) begin
          ev_k[n_ev] = 1; ev_a[n_ev] = int'(wr_addr); ev_d[n_ev] = int'(wr_data);
          n_ev++;
        end
        wr_idx++;
        wcnt = 0;
        cur_delay = pick_delay(wr_idx);
      end else if (wr_req) begin
        wcnt++;
        stall_cycles = wcnt;
      end else begin
        wcnt = 0;
      end
      if (sync) run_len++;
      else if (run_len > 0) begin
        if (n_ev < 16) begin
          ev_k[n_ev] = 2; ev_a[n_ev] = 0; ev_d[n_ev] = run_len;
          n_ev++;
        end
        run_len = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic expect_ev(int i, int k, int a, int d, string req);
    chk(ev_k[i] == k && ev_a[i] == a && ev_d[i] == d, req, ev_d[i], d);
  endtask

  task automatic run_seq(int len, bit alm, int dmode, int stall, bit mid_start);
    int plen, n_exp;
    bit finished;
    plen = (len == 0) ? 4 : len;
    @(negedge clk);
    sync_len = 4'(len);
    alarm = alm;
    delay_mode = dmode;
    stall_idx = stall;
    stall_cycles = 0;
    wr_idx = 0;
    cur_delay = pick_delay(0);
    for (int i = 0; i < 16; i++) begin ev_k[i] = 0; ev_a[i] = 0; ev_d[i] = 0; end
    n_ev = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: accepted start clears both flags, R2: run begins
    chk(busy && !done && !err, "R11", {busy, done, err}, 3'b100);
    finished = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      start = (mid_start && (c == 3 || c == 12)) ? 1'b1 : 1'b0;
      if (done || err) begin finished = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(finished, "R2", finished, 1);
    if (stall == 0) n_exp = 0;
    else if (stall == 1) n_exp = 2;
    else if (stall == 2) n_exp = 3;
    else if (stall == 3) n_exp = 5;
    else n_exp = alm ? 5 : 6;
    chk(n_ev == n_exp, mid_start ? "R2" : "R8", n_ev, n_exp);
    if (n_exp > 0) expect_ev(0, 1, PLL_A, 16'h0003, "R3");
    if (n_exp > 1) expect_ev(1, 2, 0, plen, "R4");
    if (n_exp > 2) expect_ev(2, 1, PLL_A, 16'h0001, "R5");
    if (n_exp > 3) expect_ev(3, 1, CLK_A, 16'h0001, "R6");
    if (n_exp > 4) expect_ev(4, 2, 0, plen, "R6");
    if (n_exp > 5) expect_ev(5, 1, CLK_A, 16'h0000, "R8");
    if (stall >= 0) begin
      chk(err && !done && err_code == 2'd2, "R10", err_code, 2);
      chk(stall_cycles == TMO, "R10", stall_cycles, TMO);
      chk(!wr_req, "R10", wr_req, 0);
    end else if (alm) begin
      chk(err && !done && err_code == 2'd1, "R7", err_code, 1);
    end else begin
      chk(done && !err && err_code == 2'd0, "R8", {done, err, err_code}, 4'b1000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wr_req && !sync && !busy && !done && !err && err_code == 0, "R1",
        {wr_req, sync, busy, done, err, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_req && !sync && !busy && !done && !err, "R1",
        {wr_req, sync, busy, done, err}, 0);

    run_seq(0, 1'b0, 2, -1, 1'b0);          // R4 default width
    repeat (20) @(negedge clk);
    chk(done && !err && !busy, "R11", {done, err, busy}, 3'b100);
    run_seq(1, 1'b0, 1, -1, 1'b0);          // R10 ack in last allowed cycle
    run_seq(15, 1'b0, 0, -1, 1'b0);
    run_seq(3, 1'b1, 0, -1, 1'b0);          // R7 alarm
    repeat (10) @(negedge clk);
    chk(err && err_code == 2'd1 && !wr_req, "R11", err_code, 1);
    for (int s = 0; s < 4; s++) run_seq(2, 1'b0, 0, s, 1'b0);  // R10 stall per write
    run_seq(5, 1'b0, 0, -1, 1'b1);          // R2 start while busy

    for (int r = 0; r < 8; r++) begin
      run_seq(int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0), 0, -1, 1'b0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end

endmodule